// File: doc/BRIEF.md
# Debounced Keypad Matrix Scanner

This block watches a keyboard matrix of up to 8 row lines and 10 column lines, which gives at most 80 keys. Two mask inputs choose which rows and which columns belong to the keypad. While nothing is happening it sleeps: every enabled column is driven low and the rows, which have pull-ups, are watched. A key closes a row onto a column, so a low enabled row means that some key is down, and that wakes the scanner.

Once awake, the scanner makes sweeps. In a sweep it drives one enabled column low at a time, in ascending order, with every other column high. It waits a few settle cycles, latches the rows and then looks at the keys of that column one per cycle. Each key has its own debounced state and a counter of consecutive sweeps in which the raw level differed from that state. A sweep starts at wake-up and then once every `TICK_CYC` cycles. When a key has read the opposite level for `DB_SAMPLES` sweeps in a row, its state flips and one event byte is produced. With the default 1 ms tick and 11 samples, a press or a release must be seen for at least 10 ms before it is reported. When no key is held and no counter is running, the scanner goes back to sleep.

Events leave on a valid/ready output. A byte stays on `evt_data` with `evt_valid` high until the consumer raises `evt_ready`. While an event is waiting, the key walk stops on the key it has reached. Back-pressure can therefore only lengthen the time between sweeps, and it never loses an event or shortens a debounce interval.

Top module: `kps_scanner`

## Requirements
- R1: After reset `evt_valid` is low, the scanner is asleep, and `col_drive` is low on every enabled column and high on every disabled one.
- R2: While asleep, `col_drive` equals the inverse of `col_en`. A low `row_sense` bit on any enabled row wakes the scanner and starts a sweep within a few cycles.
- R3: During a sweep, exactly one `col_drive` bit is low. It is always an enabled column, and the columns are visited in ascending index order.
- R4: A key that reads as closed on `DB_SAMPLES` consecutive sweeps produces exactly one press event. With a tick of T cycles this happens no earlier than (DB_SAMPLES-1)*T cycles after the key closes, and no further events follow while the key stays closed.
- R5: A closure that lasts fewer sweeps than `DB_SAMPLES` produces no event.
- R6: A key that was reported pressed and then reads as open on `DB_SAMPLES` consecutive sweeps produces exactly one release event, no earlier than (DB_SAMPLES-1)*T cycles after it opens.
- R7: Keys that change together are each reported by their own event.
- R8: Event byte layout: bit 7 is 1 for a press and 0 for a release. Bits 6:0 hold the key code row*COLS+column+1, so key (0,0) is code 1 and key (7,9) is code 80 with the default size.
- R9: When no key is held and no debounce count is running, the scanner returns to sleep and the columns stay in the sleep pattern with no further sweeps.
- R10: Rows and columns outside the masks are ignored. A disabled column is never driven low, a low disabled row does not wake the scanner, and keys on disabled lines never produce events.
- R11: While `evt_valid` is high and `evt_ready` is low, `evt_valid` stays high and `evt_data` holds its value. The transfer takes place on a clock edge where both are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| row_en | input | ROWS | Row enable mask, 1 = line is a keypad row |
| col_en | input | COLS | Column enable mask, 1 = line is a keypad column |
| row_sense | input | ROWS | Sampled row levels (pulled up, low = key closed onto a low column) |
| col_drive | output | COLS | Column drive levels, 0 = driven low |
| evt_valid | output | 1 | Event byte available |
| evt_ready | input | 1 | Consumer accepts the event byte |
| evt_data | output | 8 | Event byte: press flag in bit 7, key code in bits 6:0 |

## Verification
The bench models the matrix itself, pulling a row low only where a closed key meets a low column. One key held and then let go tells the press path from the release path and bounds each delay against the tick. A closure shorter than the debounce window tells a true debounce from plain edge detection. Two keys in different columns show that keys changing together are reported separately. The first and last key held while the consumer withholds ready show both code limits and that the output holds its byte. Masking one row and one column, with that row forced low and a key on that column held, shows that masked lines neither wake the scanner nor report events while enabled keys still do.

// File: rtl/kps_pkg.sv
package kps_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_WALK,
    ST_WAIT
  } kps_state_e;
endpackage

// File: rtl/kps_tick.sv
module kps_tick #(
  parameter int TICK_CYC = 125000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int TW = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;
  localparam logic [TW-1:0] TICK_LAST = TW'(TICK_CYC - 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr || cnt_q == TICK_LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick = !clr && (cnt_q == TICK_LAST);
endmodule

// File: rtl/kps_col_drive.sv
module kps_col_drive #(
  parameter int COLS = 10,
  parameter int CW   = 4
) (
  input  logic            scanning,
  input  logic [CW-1:0]   col_idx,
  input  logic [COLS-1:0] col_en,
  output logic [COLS-1:0] col_drive
);
  for (genvar c = 0; c < COLS; c++) begin : g_col
    // disabled columns stay high; scanning lowers only the selected column
    assign col_drive[c] = !col_en[c] ? 1'b1
                        : (scanning ? (col_idx != CW'(c)) : 1'b0);
  end
endmodule

// File: rtl/kps_debounce_bank.sv
module kps_debounce_bank #(
  parameter int ROWS       = 8,
  parameter int COLS       = 10,
  parameter int DB_SAMPLES = 11,
  parameter int RW         = 3,
  parameter int CW         = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            eval,
  input  logic [RW-1:0]   r_idx,
  input  logic [CW-1:0]   c_idx,
  input  logic            raw_press,
  input  logic [ROWS-1:0] row_en,
  input  logic [COLS-1:0] col_en,
  output logic            fire,
  output logic            any_active
);
  localparam int KEYS = ROWS * COLS;
  localparam int DBW  = (DB_SAMPLES > 1) ? $clog2(DB_SAMPLES) : 1;
  localparam logic [DBW-1:0] DB_LAST = DBW'(DB_SAMPLES - 1);

  logic [KEYS-1:0] flip;
  logic [KEYS-1:0] act;

  for (genvar k = 0; k < KEYS; k++) begin : g_key
    localparam int KR = k / COLS;
    localparam int KC = k % COLS;

    logic           stab_q;
    logic [DBW-1:0] cnt_q;
    logic           off;
    logic           hit;

    assign off     = !row_en[KR] || !col_en[KC];
    assign hit     = eval && !off && (r_idx == RW'(KR)) && (c_idx == CW'(KC));
    assign flip[k] = hit && (raw_press != stab_q) && (cnt_q == DB_LAST);
    assign act[k]  = stab_q || (cnt_q != '0);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stab_q <= 1'b0;
        cnt_q  <= '0;
      end else if (off) begin
        stab_q <= 1'b0;
        cnt_q  <= '0;
      end else if (hit) begin
        if (raw_press != stab_q) begin
          if (cnt_q == DB_LAST) begin
            stab_q <= raw_press;
            cnt_q  <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end else begin
          cnt_q <= '0;
        end
      end
    end
  end

  assign fire       = |flip;
  assign any_active = |act;
endmodule

// File: rtl/kps_scanner.sv
module kps_scanner #(
  parameter int ROWS       = 8,
  parameter int COLS       = 10,
  parameter int TICK_CYC   = 125000,
  parameter int DB_SAMPLES = 11,
  parameter int SETTLE_CYC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ROWS-1:0] row_en,
  input  logic [COLS-1:0] col_en,
  input  logic [ROWS-1:0] row_sense,
  output logic [COLS-1:0] col_drive,
  output logic            evt_valid,
  input  logic            evt_ready,
  output logic [7:0]      evt_data
);
  import kps_pkg::*;

  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int CW = (COLS > 1) ? $clog2(COLS) : 1;
  localparam int SW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [RW-1:0] ROW_LAST    = RW'(ROWS - 1);
  localparam logic [SW-1:0] SETTLE_LAST = SW'(SETTLE_CYC - 1);

  kps_state_e      state_q;
  logic [CW-1:0]   col_idx;
  logic [RW-1:0]   row_idx;
  logic [SW-1:0]   settle_cnt;
  logic [ROWS-1:0] rows_q;

  logic          tick;
  logic          stall;
  logic          wake;
  logic          fire;
  logic          any_active;
  logic          raw_press;
  logic          first_found;
  logic [CW-1:0] first_col;
  logic          nxt_found;
  logic [CW-1:0] nxt_col;
  logic [6:0]    code;

  assign stall     = evt_valid && !evt_ready;
  assign wake      = |(~row_sense & row_en);
  assign raw_press = !rows_q[row_idx];
  assign code      = 7'(row_idx * COLS + col_idx + 1);

  // lowest enabled column, and lowest enabled column above the current one
  always_comb begin
    first_found = 1'b0;
    first_col   = '0;
    nxt_found   = 1'b0;
    nxt_col     = '0;
    for (int c = COLS - 1; c >= 0; c--) begin
      if (col_en[c]) begin
        first_found = 1'b1;
        first_col   = CW'(c);
        if (CW'(c) > col_idx) begin
          nxt_found = 1'b1;
          nxt_col   = CW'(c);
        end
      end
    end
  end

  kps_tick #(.TICK_CYC(TICK_CYC)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (state_q == ST_IDLE),
    .tick  (tick)
  );

  kps_col_drive #(.COLS(COLS), .CW(CW)) u_cols (
    .scanning  (state_q == ST_SETTLE || state_q == ST_WALK),
    .col_idx   (col_idx),
    .col_en    (col_en),
    .col_drive (col_drive)
  );

  kps_debounce_bank #(
    .ROWS(ROWS), .COLS(COLS), .DB_SAMPLES(DB_SAMPLES), .RW(RW), .CW(CW)
  ) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .eval       (state_q == ST_WALK && !stall),
    .r_idx      (row_idx),
    .c_idx      (col_idx),
    .raw_press  (raw_press),
    .row_en     (row_en),
    .col_en     (col_en),
    .fire       (fire),
    .any_active (any_active)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      col_idx    <= '0;
      row_idx    <= '0;
      settle_cnt <= '0;
      rows_q     <= '1;
      evt_valid  <= 1'b0;
      evt_data   <= '0;
    end else begin
      if (evt_valid && evt_ready) begin
        evt_valid <= 1'b0;
      end
      if (fire) begin
        evt_valid <= 1'b1;
        evt_data  <= {raw_press, code};
      end
      unique case (state_q)
        ST_IDLE: begin
          if (wake && first_found) begin
            state_q    <= ST_SETTLE;
            col_idx    <= first_col;
            settle_cnt <= '0;
          end
        end
        ST_SETTLE: begin
          if (settle_cnt == SETTLE_LAST) begin
            rows_q  <= row_sense;
            row_idx <= '0;
            state_q <= ST_WALK;
          end else begin
            settle_cnt <= settle_cnt + 1'b1;
          end
        end
        ST_WALK: begin
          if (!stall) begin
            if (row_idx == ROW_LAST) begin
              if (nxt_found) begin
                col_idx    <= nxt_col;
                settle_cnt <= '0;
                state_q    <= ST_SETTLE;
              end else begin
                state_q <= ST_WAIT;
              end
            end else begin
              row_idx <= row_idx + 1'b1;
            end
          end
        end
        ST_WAIT: begin
          if (!any_active) begin
            state_q <= ST_IDLE;
          end else if (tick && first_found) begin
            state_q    <= ST_SETTLE;
            col_idx    <= first_col;
            settle_cnt <= '0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/kps_scanner_chk.sv
module kps_scanner_chk #(
  parameter int ROWS = 8,
  parameter int COLS = 10
) (
  input logic               clk,
  input logic               rst_n,
  input logic [COLS-1:0]    col_en,
  input logic [COLS-1:0]    col_drive,
  input logic               evt_valid,
  input logic               evt_ready,
  input logic [7:0]         evt_data,
  input kps_pkg::kps_state_e state_q
);
  import kps_pkg::*;
  localparam int KEYS = ROWS * COLS;

  // R11
  evt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !evt_ready) |=> (evt_valid && $stable(evt_data)));

  // R8
  code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> (evt_data[6:0] != 7'd0 && evt_data[6:0] <= 7'(KEYS)));

  // R10
  dis_col_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_drive | col_en) == {COLS{1'b1}});

  // R3
  one_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SETTLE || state_q == ST_WALK) |-> ($countones(~col_drive) == 1));

  // R2
  idle_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> (col_drive == ~col_en));
endmodule

bind kps_scanner kps_scanner_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .col_en    (col_en),
  .col_drive (col_drive),
  .evt_valid (evt_valid),
  .evt_ready (evt_ready),
  .evt_data  (evt_data),
  .state_q   (state_q)
);

// File: tb/kps_scanner_test.sv
module kps_scanner_test;
  localparam int ROWS = 8;
  localparam int COLS = 10;
  localparam int TICK = 200;
  localparam int DBS  = 4;
  localparam int SWEEP = COLS * (2 + ROWS);

  logic            clk = 1'b0;
  logic            rst_n;
  logic [ROWS-1:0] row_en;
  logic [COLS-1:0] col_en;
  logic [ROWS-1:0] row_sense;
  logic [COLS-1:0] col_drive;
  logic            evt_valid;
  logic            evt_ready;
  logic [7:0]      evt_data;

  logic [COLS-1:0] pressed [ROWS];
  logic [ROWS-1:0] force_low;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;
  int ev_n = 0;
  logic [7:0] ev_data [64];
  int ev_cyc [64];
  int scan_err = 0;
  int scans_seen = 0;
  int last_col = 0;
  bit in_sweep = 0;
  bit done = 0;

  always #4 clk = ~clk;

  kps_scanner #(
    .ROWS(ROWS), .COLS(COLS), .TICK_CYC(TICK), .DB_SAMPLES(DBS), .SETTLE_CYC(2)
  ) uut (
    .clk(clk), .rst_n(rst_n), .row_en(row_en), .col_en(col_en),
    .row_sense(row_sense), .col_drive(col_drive), .evt_valid(evt_valid),
    .evt_ready(evt_ready), .evt_data(evt_data)
  );

  // matrix model: a row is low if a closed key meets a low column
  always_comb begin
    for (int r = 0; r < ROWS; r++) begin
      row_sense[r] = !force_low[r] && !(|(pressed[r] & ~col_drive));
    end
  end

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && evt_valid && evt_ready && ev_n < 64) begin
      ev_data[ev_n] = evt_data;
      ev_cyc[ev_n]  = cyc;
      ev_n = ev_n + 1;
    end
  end

  // column drive monitor for R3
  always @(negedge clk) begin
    if (rst_n) begin
      logic [COLS-1:0] lows;
      lows = ~col_drive;
      if ((lows & ~col_en) != '0) scan_err++;
      if (col_drive != ~col_en) begin
        if ($countones(lows) != 1) begin
          scan_err++;
        end else begin
          for (int c = 0; c < COLS; c++) begin
            if (lows[c]) begin
              if (in_sweep && c < last_col) scan_err++;
              last_col = c;
            end
          end
          in_sweep = 1;
          scans_seen++;
        end
      end else begin
        in_sweep = 0;
        last_col = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_ev(input int target, input int maxc, output bit got);
    got = 0;
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk);
      if (ev_n >= target) begin
        got = 1;
        break;
      end
    end
  endtask

  task automatic t_reset();
    chk(col_drive == ~col_en, "R1", "reset column drive", int'(col_drive), int'(~col_en));
    chk(!evt_valid, "R1", "reset evt_valid", int'(evt_valid), 0);
  endtask

  task automatic t_single();
    int base, t0, lat, bad;
    bit got;
    base = ev_n;
    t0 = cyc;
    pressed[2][4] = 1'b1;
    repeat (3) @(negedge clk);
    chk(col_drive != ~col_en, "R2", "wake on row low", int'(col_drive), 0);
    wait_ev(base + 1, 2000, got);
    lat = ev_cyc[base] - t0;
    chk(got && ev_data[base] == 8'h99, "R8", "press byte key(2,4)", int'(ev_data[base]), 'h99);
    chk(got && lat >= (DBS - 1) * TICK && lat <= DBS * TICK + SWEEP + 20,
        "R4", "press delay", lat, (DBS - 1) * TICK);
    repeat (1000) @(negedge clk);
    chk(ev_n == base + 1, "R4", "events while held", ev_n - base, 1);
    base = ev_n;
    t0 = cyc;
    pressed[2][4] = 1'b0;
    wait_ev(base + 1, 2000, got);
    lat = ev_cyc[base] - t0;
    chk(got && ev_data[base] == 8'h19, "R6", "release byte key(2,4)", int'(ev_data[base]), 'h19);
    chk(got && lat >= (DBS - 1) * TICK && lat <= DBS * TICK + SWEEP + 20,
        "R6", "release delay", lat, (DBS - 1) * TICK);
    repeat (300) @(negedge clk);
    bad = 0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (col_drive != ~col_en) bad++;
    end
    chk(bad == 0, "R9", "sleep pattern after release", bad, 0);
    chk(ev_n == base + 1, "R9", "no events asleep", ev_n - base, 1);
  endtask

  task automatic t_glitch();
    int base;
    base = ev_n;
    pressed[4][1] = 1'b1;
    repeat (250) @(negedge clk);
    pressed[4][1] = 1'b0;
    repeat (1500) @(negedge clk);
    chk(ev_n == base, "R5", "events from short closure", ev_n - base, 0);
    chk(col_drive == ~col_en, "R9", "asleep after short closure", int'(col_drive), int'(~col_en));
  endtask

  task automatic t_two();
    int base;
    bit got, a, b;
    base = ev_n;
    pressed[1][2] = 1'b1;
    pressed[5][6] = 1'b1;
    wait_ev(base + 2, 2500, got);
    a = (ev_data[base] == 8'h8D) || (ev_data[base + 1] == 8'h8D);
    b = (ev_data[base] == 8'hB9) || (ev_data[base + 1] == 8'hB9);
    chk(got && a && b, "R7", "two press events", int'(ev_data[base]), 'h8D);
    base = ev_n;
    pressed[1][2] = 1'b0;
    pressed[5][6] = 1'b0;
    wait_ev(base + 2, 2500, got);
    a = (ev_data[base] == 8'h0D) || (ev_data[base + 1] == 8'h0D);
    b = (ev_data[base] == 8'h39) || (ev_data[base + 1] == 8'h39);
    chk(got && a && b, "R7", "two release events", int'(ev_data[base]), 'h0D);
    repeat (400) @(negedge clk);
    chk(ev_n == base + 2, "R7", "no extra events", ev_n - base, 2);
  endtask

  task automatic t_backpressure();
    int base, bad, waited;
    bit got;
    logic [7:0] held;
    base = ev_n;
    evt_ready = 1'b0;
    pressed[0][0] = 1'b1;
    pressed[7][9] = 1'b1;
    waited = 0;
    while (!evt_valid && waited < 2500) begin
      @(negedge clk);
      waited++;
    end
    held = evt_data;
    chk(evt_valid && held == 8'h81, "R8", "first key code", int'(held), 'h81);
    bad = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (!evt_valid || evt_data != held) bad++;
    end
    chk(bad == 0, "R11", "byte held while not ready", bad, 0);
    chk(ev_n == base, "R11", "no transfer without ready", ev_n - base, 0);
    evt_ready = 1'b1;
    wait_ev(base + 2, 2500, got);
    chk(got && ev_data[base] == 8'h81, "R11", "held byte delivered", int'(ev_data[base]), 'h81);
    chk(got && ev_data[base + 1] == 8'hD0, "R8", "last key code", int'(ev_data[base + 1]), 'hD0);
    base = ev_n;
    pressed[0][0] = 1'b0;
    pressed[7][9] = 1'b0;
    wait_ev(base + 2, 2500, got);
    repeat (400) @(negedge clk);
  endtask

  task automatic t_disabled();
    int base, bad;
    bit got;
    row_en = 8'h7F;
    col_en = 10'h1FF;
    repeat (5) @(negedge clk);
    chk(col_drive == 10'h200, "R10", "masked column high asleep", int'(col_drive), 'h200);
    base = ev_n;
    force_low[7] = 1'b1;
    bad = 0;
    for (int i = 0; i < 800; i++) begin
      @(negedge clk);
      if (col_drive != 10'h200) bad++;
    end
    chk(bad == 0, "R10", "masked row does not wake", bad, 0);
    force_low[7] = 1'b0;
    pressed[3][9] = 1'b1;
    repeat (1200) @(negedge clk);
    chk(ev_n == base, "R10", "masked column key silent", ev_n - base, 0);
    pressed[3][9] = 1'b0;
    pressed[3][0] = 1'b1;
    wait_ev(base + 1, 2000, got);
    chk(got && ev_data[base] == 8'h9F, "R2", "enabled key under masks", int'(ev_data[base]), 'h9F);
    pressed[3][0] = 1'b0;
    wait_ev(base + 2, 2500, got);
    chk(got && ev_data[base + 1] == 8'h1F, "R6", "release under masks", int'(ev_data[base + 1]), 'h1F);
    repeat (400) @(negedge clk);
    row_en = '1;
    col_en = '1;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    for (int r = 0; r < ROWS; r++) pressed[r] = '0;
    force_low = '0;
    row_en = '1;
    col_en = '1;
    evt_ready = 1'b1;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_glitch();
    t_two();
    t_backpressure();
    t_disabled();
    chk(scan_err == 0, "R3", "column drive order violations", scan_err, 0);
    chk(scans_seen > 0, "R3", "sweep cycles observed", scans_seen, 1);
    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    #(150000 * 8);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule